// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block runs the digital side of a dual-slope integrating converter. It drives a two-bit phase-select output that moves an external integrator, reference switch and comparator through one conversion. The sequence is auto-zero, then fixed-length signal integration, then reference de-integration, then integrator zero. The analog parts, the comparator and any scaling of the result to volts sit outside the block.

A start request launches one conversion. Signal integration lasts a fixed, parameter-set number of clocks. The input's sign is taken from the comparator only on the final clock of that phase, because the comparator may chatter early in the phase when the input is near zero. During de-integration the block counts clocks until the comparator falls, which marks the integrator's zero crossing. It then removes a fixed number of clocks from the count: the comparator's own delay plus the latency of its input synchroniser. It reports the result as a sign and a magnitude, with a one-clock done pulse. If no crossing arrives within a maximum count, the block stops and flags overrange.

Top module: `dslope_seq`

## Requirements
- R1: `phase_o` encodes the front-end phase as 00 = integrator zero, 01 = auto-zero, 10 = signal integrate, 11 = reference de-integrate. After an accepted start the phases run 01, 10, 11, 00 in that order, then the block returns to idle with `phase_o` = 00 and `busy_o` low.
- R2: `phase_o` stays constant within a phase. Auto-zero lasts `AZ_CYCLES` clocks, signal integrate lasts `INT_CYCLES` clocks and integrator zero lasts `ZERO_CYCLES` clocks.
- R3: The sign is taken from the synchronised comparator on the last clock of signal integrate only. `neg_o` = 1 (negative input) when the comparator was low there and 0 when it was high. Earlier comparator activity in that phase does not affect `neg_o`.
- R4: Comparator edges outside de-integrate, including any in auto-zero, neither end a count nor change the result.
- R5: Let n be the number of clocks from the first de-integrate clock to the clock in which `cmp_i` goes low (n = 0 when it falls in that first clock). If the crossing is accepted, `mag_o` = n − `CMP_DLY`, floored at 0, and `ovr_o` = 0.
- R6: A fall is accepted only if it reaches the synchronised comparator within the first `MAX_DEINT` de-integrate clocks, which means n ≤ `MAX_DEINT` − 3. Otherwise de-integrate ends after `MAX_DEINT` clocks, with `ovr_o` = 1 and `mag_o` = `MAX_DEINT`.
- R7: `done_o` is high for exactly one clock: the first clock of integrator zero. `neg_o`, `mag_o` and `ovr_o` take new values only with `done_o` and hold until the next one.
- R8: `start_i` is acted on only while `busy_o` is low. A start in any phase of a running conversion does not change the phase sequence and adds no conversion.
- R9: After reset, `phase_o` = 00 and `busy_o`, `done_o`, `neg_o`, `ovr_o` and `mag_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Conversion request, acted on while idle |
| cmp_i | input | 1 | Asynchronous comparator output from the front end |
| phase_o | output | 2 | Front-end phase select |
| busy_o | output | 1 | High from start acceptance to the end of integrator zero |
| done_o | output | 1 | One-clock result-valid pulse |
| neg_o | output | 1 | Sign of result, 1 = negative input |
| mag_o | output | MAG_W | Corrected de-integrate count, or MAX_DEINT on overrange |
| ovr_o | output | 1 | No zero crossing within MAX_DEINT clocks |

## Verification
Conversions are run with a positive input (comparator high through integrate) and with a negative input (comparator low through integrate, then rising at the start of de-integrate). Each is run with the comparator fall placed at several distances into de-integrate. Fall positions at, just below and just above the delay correction check the floor at zero. Positions at the last accepted clock and one past it, together with a comparator that never falls, separate a normal result from overrange. Comparator chatter through auto-zero and early integrate, settling to either level, shows that only the final integrate level sets the sign and that stray edges end nothing. Start pulses during integrate and during integrator zero show that a request made while busy neither restarts nor stretches a conversion.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZ,
    ST_INT,
    ST_DEINT,
    ST_ZERO
  } seq_state_e;

  localparam logic [1:0] PH_ZERO  = 2'b00;
  localparam logic [1:0] PH_AZ    = 2'b01;
  localparam logic [1:0] PH_INT   = 2'b10;
  localparam logic [1:0] PH_DEINT = 2'b11;

  function automatic logic [1:0] phase_code(seq_state_e s);
    case (s)
      ST_AZ:    return PH_AZ;
      ST_INT:   return PH_INT;
      ST_DEINT: return PH_DEINT;
      default:  return PH_ZERO;
    endcase
  endfunction

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;
  logic              prev_q;

  assign sh_d = {sh_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign q_o    = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];

endmodule

// File: rtl/dslope_timer.sv
module dslope_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          expired_o
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/dslope_ctrl.sv
module dslope_ctrl
  import dslope_pkg::*;
#(
  parameter int AZ_CYCLES   = 16,
  parameter int INT_CYCLES  = 64,
  parameter int ZERO_CYCLES = 8,
  parameter int TW          = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          tmr_expired_i,
  input  logic          deint_stop_i,
  output seq_state_e    state_o,
  output logic          tmr_load_o,
  output logic [TW-1:0] tmr_val_o,
  output logic          sign_cap_o,
  output logic          cnt_clr_o,
  output logic          finish_o
);

  localparam logic [TW-1:0] AZ_LOAD   = TW'(AZ_CYCLES - 1);
  localparam logic [TW-1:0] INT_LOAD  = TW'(INT_CYCLES - 1);
  localparam logic [TW-1:0] ZERO_LOAD = TW'(ZERO_CYCLES - 1);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    sign_cap_o = 1'b0;
    cnt_clr_o  = 1'b0;
    finish_o   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d    = ST_AZ;
          tmr_load_o = 1'b1;
          tmr_val_o  = AZ_LOAD;
        end
      end
      ST_AZ: begin
        if (tmr_expired_i) begin
          state_d    = ST_INT;
          tmr_load_o = 1'b1;
          tmr_val_o  = INT_LOAD;
        end
      end
      ST_INT: begin
        if (tmr_expired_i) begin
          state_d    = ST_DEINT;
          sign_cap_o = 1'b1;
          cnt_clr_o  = 1'b1;
        end
      end
      ST_DEINT: begin
        if (deint_stop_i) begin
          state_d    = ST_ZERO;
          finish_o   = 1'b1;
          tmr_load_o = 1'b1;
          tmr_val_o  = ZERO_LOAD;
        end
      end
      ST_ZERO: begin
        if (tmr_expired_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/dslope_deint.sv
module dslope_deint #(
  parameter int MAX_DEINT = 200,
  parameter int CORR      = 5,
  parameter int MAG_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             fall_i,
  input  logic             cmp_i,
  input  logic             sign_cap_i,
  input  logic             finish_i,
  output logic             stop_o,
  output logic             done_o,
  output logic             neg_o,
  output logic             ovr_o,
  output logic [MAG_W-1:0] mag_o
);

  localparam logic [MAG_W-1:0] CNT_LAST = MAG_W'(MAX_DEINT - 1);
  localparam logic [MAG_W-1:0] CNT_SAT  = MAG_W'(MAX_DEINT);
  localparam logic [MAG_W-1:0] CORR_V   = MAG_W'(CORR);

  logic [MAG_W-1:0] cnt_q, cnt_d;
  logic [MAG_W-1:0] corr_cnt;
  logic             sign_q, sign_d;
  logic             done_q;
  logic             neg_q, ovr_q;
  logic [MAG_W-1:0] mag_q;
  logic             cnt_en;

  assign stop_o   = run_i & (fall_i | (cnt_q == CNT_LAST));
  assign cnt_en   = run_i & ~stop_o;
  assign corr_cnt = (cnt_q >= CORR_V) ? (cnt_q - CORR_V) : '0;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
    sign_d = sign_q;
    if (sign_cap_i) begin
      sign_d = ~cmp_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sign_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sign_q <= sign_d;
      done_q <= finish_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
      ovr_q <= 1'b0;
      mag_q <= '0;
    end else if (finish_i) begin
      neg_q <= sign_q;
      ovr_q <= ~fall_i;
      mag_q <= fall_i ? corr_cnt : CNT_SAT;
    end
  end

  assign done_o = done_q;
  assign neg_o  = neg_q;
  assign ovr_o  = ovr_q;
  assign mag_o  = mag_q;

endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
  import dslope_pkg::*;
#(
  parameter int AZ_CYCLES   = 16,
  parameter int INT_CYCLES  = 64,
  parameter int ZERO_CYCLES = 8,
  parameter int MAX_DEINT   = 200,
  parameter int CMP_DLY     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MAG_W       = $clog2(MAX_DEINT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic [1:0]       phase_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             neg_o,
  output logic [MAG_W-1:0] mag_o,
  output logic             ovr_o
);

  localparam int TW   = $clog2(max3(AZ_CYCLES, INT_CYCLES, ZERO_CYCLES) + 1);
  localparam int CORR = CMP_DLY + SYNC_STAGES;

  logic [1:0]    rst_pipe_q;
  logic          rst_core_n;
  seq_state_e    state;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          sign_cap, cnt_clr, finish, deint_stop;
  logic          cmp_sync, cmp_fall;

  // reset asserts at once, releases after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .d_i    (cmp_i),
    .q_o    (cmp_sync),
    .fall_o (cmp_fall)
  );

  dslope_timer #(.TW(TW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_expired)
  );

  dslope_ctrl #(
    .AZ_CYCLES   (AZ_CYCLES),
    .INT_CYCLES  (INT_CYCLES),
    .ZERO_CYCLES (ZERO_CYCLES),
    .TW          (TW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .start_i       (start_i),
    .tmr_expired_i (tmr_expired),
    .deint_stop_i  (deint_stop),
    .state_o       (state),
    .tmr_load_o    (tmr_load),
    .tmr_val_o     (tmr_val),
    .sign_cap_o    (sign_cap),
    .cnt_clr_o     (cnt_clr),
    .finish_o      (finish)
  );

  dslope_deint #(
    .MAX_DEINT (MAX_DEINT),
    .CORR      (CORR),
    .MAG_W     (MAG_W)
  ) u_deint (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .run_i      (state == ST_DEINT),
    .clr_i      (cnt_clr),
    .fall_i     (cmp_fall),
    .cmp_i      (cmp_sync),
    .sign_cap_i (sign_cap),
    .finish_i   (finish),
    .stop_o     (deint_stop),
    .done_o     (done_o),
    .neg_o      (neg_o),
    .ovr_o      (ovr_o),
    .mag_o      (mag_o)
  );

  assign phase_o = phase_code(state);
  assign busy_o  = (state != ST_IDLE);

endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk
  import dslope_pkg::*;
#(
  parameter int MAX_DEINT = 200,
  parameter int MAG_W     = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [1:0]       phase_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [MAG_W-1:0] mag_o
);

  // R1: auto-zero is followed only by signal integrate
  p_az_then_int_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_AZ) |=> (phase_o == PH_AZ || phase_o == PH_INT));

  // R1: signal integrate is followed only by de-integrate
  p_int_then_deint_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_INT) |=> (phase_o == PH_INT || phase_o == PH_DEINT));

  // R7: leaving de-integrate comes with the done pulse
  p_deint_exit_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == PH_DEINT) |=> (phase_o == PH_DEINT || done_o));

  // R7: done lasts one clock
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: result holds between done pulses
  p_mag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(mag_o));

  // R8: idle start enters auto-zero
  p_idle_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (phase_o == PH_AZ));

  // R8: auto-zero is never re-entered from a busy phase
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && phase_o != PH_AZ) |=> (phase_o != PH_AZ));

  // R6: overrange reports the saturated count
  p_ovr_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && ovr_o) |-> (mag_o == MAG_W'(MAX_DEINT)));

  // R5: an accepted crossing reports less than the saturated count
  p_norm_below_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ovr_o) |-> (mag_o < MAG_W'(MAX_DEINT)));

endmodule

bind dslope_seq dslope_seq_chk #(
  .MAX_DEINT (MAX_DEINT),
  .MAG_W     (MAG_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .start_i (start_i),
  .phase_o (phase_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .ovr_o   (ovr_o),
  .mag_o   (mag_o)
);

// File: tb/dslope_seq_bench.sv
`timescale 1ns/1ps
module dslope_seq_bench;

  localparam int AZC  = 16;
  localparam int INTC = 64;
  localparam int ZC   = 8;
  localparam int MAXD = 200;
  localparam int DLY  = 3;
  localparam int MW   = $clog2(MAXD + 1);

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic          cmp_i;
  logic [1:0]    phase_o;
  logic          busy_o;
  logic          done_o;
  logic          neg_o;
  logic [MW-1:0] mag_o;
  logic          ovr_o;

  typedef struct {
    logic neg;
    logic ovr;
    int   mag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp;
  int   n_bad;
  bit   finished;

  dslope_seq #(
    .AZ_CYCLES   (AZC),
    .INT_CYCLES  (INTC),
    .ZERO_CYCLES (ZC),
    .MAX_DEINT   (MAXD),
    .CMP_DLY     (DLY)
  ) u_dslope_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .cmp_i   (cmp_i),
    .phase_o (phase_o),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .neg_o   (neg_o),
    .mag_o   (mag_o),
    .ovr_o   (ovr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor: compare each result against the queue
  logic done_prev;
  int   last_mag;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        check("R7 done single clock", int'(done_prev), 0);
        if (exp_q.size() == 0) begin
          check("R8 unexpected conversion", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check("R3 sign", int'(neg_o), int'(e.neg));
          check("R6 overrange flag", int'(ovr_o), int'(e.ovr));
          check("R5 magnitude", int'(mag_o), e.mag);
          check("R7 done in first zero clock", int'(phase_o), 0);
        end
        last_mag = int'(mag_o);
      end else if (int'(mag_o) != last_mag) begin
        check("R7 result held", int'(mag_o), last_mag);
      end
      done_prev = done_o;
    end
  end

  // phase monitor: order and durations
  logic [1:0] ph_prev;
  logic       busy_prev;
  int         run_len;
  int         zero_len;
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_o != ph_prev) begin
        case (ph_prev)
          2'b01: begin
            check("R2 auto-zero length", run_len, AZC);
            check("R1 order after auto-zero", int'(phase_o), 2);
          end
          2'b10: begin
            check("R2 integrate length", run_len, INTC);
            check("R1 order after integrate", int'(phase_o), 3);
          end
          2'b11: check("R1 order after de-integrate", int'(phase_o), 0);
          default: check("R1 order from idle", int'(phase_o), 1);
        endcase
        run_len = 1;
      end else begin
        run_len++;
      end
      if (busy_o && phase_o == 2'b00) zero_len++;
      if (busy_prev && !busy_o) begin
        check("R2 zero length", zero_len, ZC);
        check("R1 idle phase", int'(phase_o), 0);
        zero_len = 0;
      end
      ph_prev   = phase_o;
      busy_prev = busy_o;
    end
  end

  // driver: one conversion, expected result pushed to the queue
  task automatic convert(input bit neg, input int n, input bit chatter,
                         input bit poke_int, input bit poke_zero);
    exp_t e;
    int   k;
    e.neg = neg;
    if (n >= 0 && n <= MAXD - 3) begin
      e.ovr = 1'b0;
      e.mag = (n > DLY) ? n - DLY : 0;
    end else begin
      e.ovr = 1'b1;
      e.mag = MAXD;
    end
    exp_q.push_back(e);
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    k = 0;
    while (phase_o != 2'b11) begin
      if (phase_o == 2'b10) k++;
      if (chatter && (phase_o == 2'b01 || (phase_o == 2'b10 && k < INTC - 8)))
        cmp_i = ~cmp_i;
      else if (phase_o == 2'b10)
        cmp_i = ~neg;
      start_i = (poke_int && phase_o == 2'b10 && k == 10);
      @(negedge clk);
    end
    start_i = 1'b0;
    cmp_i = 1'b1;
    if (n >= 0) begin
      repeat (n) @(negedge clk);
      cmp_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    if (poke_zero) begin
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    cmp_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 stays idle after conversion", int'(busy_o), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    n_cmp = 0; n_bad = 0; finished = 1'b0;
    done_prev = 1'b0; last_mag = 0;
    ph_prev = 2'b00; busy_prev = 1'b0; run_len = 0; zero_len = 0;
    rst_n = 1'b0; start_i = 1'b0; cmp_i = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check("R9 phase", int'(phase_o), 0);
    check("R9 busy", int'(busy_o), 0);
    check("R9 done", int'(done_o), 0);
    check("R9 sign", int'(neg_o), 0);
    check("R9 overrange", int'(ovr_o), 0);
    check("R9 magnitude", int'(mag_o), 0);

    convert(1'b0, 50, 1'b0, 1'b0, 1'b0);      // R5 positive
    convert(1'b1, 30, 1'b0, 1'b0, 1'b0);      // R3 negative
    convert(1'b0, 1, 1'b0, 1'b0, 1'b0);       // R5 floor
    convert(1'b0, DLY, 1'b0, 1'b0, 1'b0);     // R5 exactly the delay
    convert(1'b1, DLY + 1, 1'b0, 1'b0, 1'b0); // R5 one above the delay
    convert(1'b0, MAXD - 3, 1'b0, 1'b0, 1'b0);// R6 last accepted crossing
    convert(1'b0, MAXD - 2, 1'b0, 1'b0, 1'b0);// R6 one past, overrange
    convert(1'b1, -1, 1'b0, 1'b0, 1'b0);      // R6 no crossing
    convert(1'b0, 20, 1'b1, 1'b0, 1'b0);      // R3 R4 chatter settling high
    convert(1'b1, 20, 1'b1, 1'b0, 1'b0);      // R3 R4 chatter settling low
    convert(1'b0, 12, 1'b0, 1'b1, 1'b1);      // R8 start while busy
    convert(1'b0, 0, 1'b0, 1'b0, 1'b0);       // R5 fall on first clock

    check("R8 no pending results", exp_q.size(), 0);
    report();
  end

endmodule